// File: doc/BRIEF.md
# Dual-Interrupt 32-Line GPIO Controller

This block manages 32 general-purpose I/O lines behind a byte-addressable register window. Each line is an input or an output. Output lines drive the stored output data. Input lines pass through a two-stage synchronizer and feed event detection. The detector can flag rising edges, falling edges, high levels and low levels. Every detected event sets the line's bit in two independent status registers. Each status register has its own enable register and its own interrupt output, so two different consumers can service the same pin events.

Software reaches the controller with byte, halfword or word accesses. Ordinary registers take narrow writes as a read-modify-write merge. Status registers and the atomic set and clear aliases take the shifted value directly, so any byte lane that is not written counts as zeros. A level-detected line cannot be cleared while its condition still holds.

A wakeup request follows an event when the system configuration allows wakeup and the line's wakeup-enable bit is set. Writing the configuration register with bit 1 set performs a soft reset.

Top module: `gpio32_dual_irq`

## Requirements
- R1: After reset the revision register (0x00) reads REV_ID (default 0x25), configuration (0x10) reads 0, the always-ready status at 0x14 reads 1, control (0x30) reads 2, direction (0x34) reads 0xFFFFFFFF, and both status registers, both enables, wakeup enable, output data, all detect registers and both debounce registers read 0.
- R2: A direction bit of 1 makes the line an input. pin_drive is the inverse of direction, and pin_out carries the output data (0x3C) only on lines whose direction bit is 0.
- R3: The input data register (0x38) shows pin_in through a two-flop synchronizer. A pin change becomes visible in a read two clock edges after it is applied.
- R4: On an input line, a 0-to-1 change with the rising-detect bit (0x48) set, or a 1-to-0 change with the falling-detect bit (0x4C) set, sets that line's bit in both status registers (0x18 and 0x28). Output lines never raise events.
- R5: An input line that is high with its high-detect bit (0x44) set, or low with its low-detect bit (0x40) set, keeps its status bits set. Clearing the bit while the condition holds leaves it set.
- R6: Writing ones to a status register clears exactly those bits in that register only. Other bits and the other bank are unchanged.
- R7: irq_a is 1 exactly when status A ANDed with enable A (0x1C) is nonzero. irq_b is the same for status B and enable B (0x2C).
- R8: The aliases clear and set bits of their base register: 0x60/0x64 for enable A, 0x70/0x74 for enable B, 0x80/0x84 for wakeup enable (0x20), and 0x90/0x94 for output data (0x3C). The clear alias is the lower offset of each pair. Every alias reads back its base register.
- R9: wake_req is high in the cycle after an event cycle when configuration bit 2 is 1, configuration bits 4:3 are not both 0, and the line's wakeup-enable bit is 1. Otherwise it stays low.
- R10: Configuration stores the written value ANDed with 0x1D, and control keeps only bits 2:0. A configuration write with bit 1 set returns every other register to its R1 value in the same cycle.
- R11: bus_size encodes 0 = byte, 1 = halfword and 2 = word. bus_wdata is right-justified and lands at byte lane bus_addr[1:0]. On ordinary registers a narrow write replaces only the addressed lanes. On status and alias registers the lanes that are not addressed act as zeros.
- R12: bus_rdata is the addressed 32-bit register shifted right by 8 times bus_addr[1:0].
- R13: Writes to the read-only offsets 0x00, 0x14 and 0x38 and to undefined offsets change nothing, and undefined offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the register window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Read data, shifted by the byte offset |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven level for output lines |
| pin_drive | output | 32 | 1 where the line is driven as an output |
| irq_a | output | 1 | Interrupt of bank A |
| irq_b | output | 1 | Interrupt of bank B |
| wake_req | output | 1 | Wakeup request |

## Verification
The assertions watch several rules on every cycle. Status bits stay set unless their own bank is written, the two banks stay equal while neither is cleared, events never appear on output lines, a level condition forces its status bit in the next cycle, wakeup never fires while the configuration forbids it, and a soft reset clears state in one cycle. Other behaviours need the bench's scenarios: byte-lane merging against zero-filled lanes, alias arithmetic, the exact synchronizer latency, and the irq outputs under random level and enable patterns.

// File: rtl/gpio32_pkg.sv
package gpio32_pkg;

  localparam int unsigned DW = 32;

  // Register offsets (word aligned)
  localparam logic [7:0] A_REV      = 8'h00;
  localparam logic [7:0] A_SYSCFG   = 8'h10;
  localparam logic [7:0] A_SYSSTAT  = 8'h14;
  localparam logic [7:0] A_STAT_A   = 8'h18;
  localparam logic [7:0] A_EN_A     = 8'h1C;
  localparam logic [7:0] A_WAKE_EN  = 8'h20;
  localparam logic [7:0] A_STAT_B   = 8'h28;
  localparam logic [7:0] A_EN_B     = 8'h2C;
  localparam logic [7:0] A_CTRL     = 8'h30;
  localparam logic [7:0] A_DIR      = 8'h34;
  localparam logic [7:0] A_DIN      = 8'h38;
  localparam logic [7:0] A_DOUT     = 8'h3C;
  localparam logic [7:0] A_LVL_LO   = 8'h40;
  localparam logic [7:0] A_LVL_HI   = 8'h44;
  localparam logic [7:0] A_RISE     = 8'h48;
  localparam logic [7:0] A_FALL     = 8'h4C;
  localparam logic [7:0] A_DEB_EN   = 8'h50;
  localparam logic [7:0] A_DEB_TIME = 8'h54;
  localparam logic [7:0] A_EN_A_CLR = 8'h60;
  localparam logic [7:0] A_EN_A_SET = 8'h64;
  localparam logic [7:0] A_EN_B_CLR = 8'h70;
  localparam logic [7:0] A_EN_B_SET = 8'h74;
  localparam logic [7:0] A_WK_CLR   = 8'h80;
  localparam logic [7:0] A_WK_SET   = 8'h84;
  localparam logic [7:0] A_DOUT_CLR = 8'h90;
  localparam logic [7:0] A_DOUT_SET = 8'h94;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [7:0] CFG_KEEP   = 8'h1D;
  localparam logic [2:0] CTRL_RESET = 3'd2;

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [DW-1:0] base;
    case (sz)
      SZ_BYTE: base = 32'h0000_00FF;
      SZ_HALF: base = 32'h0000_FFFF;
      default: base = 32'hFFFF_FFFF;
    endcase
    return base << {off, 3'b000};
  endfunction

  function automatic logic [DW-1:0] place_lanes(input logic [DW-1:0] wd,
                                                input logic [1:0] sz,
                                                input logic [1:0] off);
    return (wd << {off, 3'b000}) & lane_mask(sz, off);
  endfunction

  function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] placed,
                                                input logic [DW-1:0] msk);
    return (cur & ~msk) | placed;
  endfunction

  function automatic logic wake_allowed(input logic [7:0] cfg);
    return cfg[2] & (cfg[4:3] != 2'b00);
  endfunction

endpackage

// File: rtl/gpio32_sync.sv
module gpio32_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[NS-2:0], d};
  end

  assign q = stg[NS-1];
endmodule

// File: rtl/gpio32_bus_lanes.sv
module gpio32_bus_lanes
  import gpio32_pkg::*;
(
  input  logic [1:0]    off,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cur,
  output logic [DW-1:0] placed,
  output logic [DW-1:0] merged
);
  logic [DW-1:0] msk;

  assign msk    = lane_mask(size, off);
  assign placed = place_lanes(wdata, size, off);
  assign merged = merge_lanes(cur, placed, msk);
endmodule

// File: rtl/gpio32_event_det.sv
module gpio32_event_det #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] is_input,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] lo_en,
  input  logic [W-1:0] hi_en,
  output logic [W-1:0] edge_ev,
  output logic [W-1:0] lvl_ev
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign edge_ev[i] = is_input[i] &
                        ((rise_en[i] & cur[i] & ~prev[i]) |
                         (fall_en[i] & ~cur[i] & prev[i]));
    assign lvl_ev[i]  = is_input[i] &
                        ((hi_en[i] & cur[i]) | (lo_en[i] & ~cur[i]));
  end
endmodule

// File: rtl/gpio32_dual_irq.sv
module gpio32_dual_irq
  import gpio32_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REV_ID      = 8'h25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_drive,
  output logic          irq_a,
  output logic          irq_b,
  output logic          wake_req
);
  // Register state
  logic [7:0]    cfg_q;
  logic [2:0]    ctrl_q;
  logic [7:0]    deb_t_q;
  logic [DW-1:0] dir_q, dout_q, lo_q, hi_q, rise_q, fall_q, deb_en_q;
  logic [DW-1:0] en_a_q, en_b_q, wk_q, st_a_q, st_b_q, prev_q;

  // Named internal events
  logic [DW-1:0] s_in, edge_ev, lvl_ev, ev_all;
  logic [DW-1:0] reg_word, placed, merged, clr_a, clr_b;
  logic [7:0]    word_addr;
  logic          wr, wr_stat_a, wr_stat_b, soft_rst;

  gpio32_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(s_in)
  );

  gpio32_event_det #(.W(DW)) u_det (
    .cur(s_in), .prev(prev_q), .is_input(dir_q),
    .rise_en(rise_q), .fall_en(fall_q), .lo_en(lo_q), .hi_en(hi_q),
    .edge_ev(edge_ev), .lvl_ev(lvl_ev)
  );

  assign ev_all    = edge_ev | lvl_ev;
  assign word_addr = {bus_addr[7:2], 2'b00};
  assign wr        = bus_sel & bus_we;

  // Read multiplexer; aliases mirror their base register
  always_comb begin
    case (word_addr)
      A_REV:                            reg_word = {24'b0, REV_ID};
      A_SYSCFG:                         reg_word = {24'b0, cfg_q};
      A_SYSSTAT:                        reg_word = 32'd1;
      A_STAT_A:                         reg_word = st_a_q;
      A_EN_A, A_EN_A_CLR, A_EN_A_SET:   reg_word = en_a_q;
      A_WAKE_EN, A_WK_CLR, A_WK_SET:    reg_word = wk_q;
      A_STAT_B:                         reg_word = st_b_q;
      A_EN_B, A_EN_B_CLR, A_EN_B_SET:   reg_word = en_b_q;
      A_CTRL:                           reg_word = {29'b0, ctrl_q};
      A_DIR:                            reg_word = dir_q;
      A_DIN:                            reg_word = s_in;
      A_DOUT, A_DOUT_CLR, A_DOUT_SET:   reg_word = dout_q;
      A_LVL_LO:                         reg_word = lo_q;
      A_LVL_HI:                         reg_word = hi_q;
      A_RISE:                           reg_word = rise_q;
      A_FALL:                           reg_word = fall_q;
      A_DEB_EN:                         reg_word = deb_en_q;
      A_DEB_TIME:                       reg_word = {24'b0, deb_t_q};
      default:                          reg_word = '0;
    endcase
  end

  assign bus_rdata = reg_word >> {bus_addr[1:0], 3'b000};

  gpio32_bus_lanes u_lanes (
    .off(bus_addr[1:0]), .size(bus_size), .wdata(bus_wdata),
    .cur(reg_word), .placed(placed), .merged(merged)
  );

  assign wr_stat_a = wr && (word_addr == A_STAT_A);
  assign wr_stat_b = wr && (word_addr == A_STAT_B);
  assign soft_rst  = wr && (word_addr == A_SYSCFG) && merged[1];
  assign clr_a     = wr_stat_a ? placed : '0;
  assign clr_b     = wr_stat_b ? placed : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ctrl_q   <= CTRL_RESET;
      deb_t_q  <= '0;
      dir_q    <= '1;
      dout_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      deb_en_q <= '0;
      en_a_q   <= '0;
      en_b_q   <= '0;
      wk_q     <= '0;
      st_a_q   <= '0;
      st_b_q   <= '0;
      prev_q   <= '0;
      wake_req <= 1'b0;
    end else begin
      prev_q   <= s_in;
      wake_req <= wake_allowed(cfg_q) & (|(ev_all & wk_q));
      st_a_q   <= (st_a_q & ~clr_a) | ev_all;
      st_b_q   <= (st_b_q & ~clr_b) | ev_all;
      if (wr) begin
        case (word_addr)
          A_SYSCFG:   cfg_q    <= merged[7:0] & CFG_KEEP;
          A_EN_A:     en_a_q   <= merged;
          A_EN_A_CLR: en_a_q   <= en_a_q & ~placed;
          A_EN_A_SET: en_a_q   <= en_a_q | placed;
          A_EN_B:     en_b_q   <= merged;
          A_EN_B_CLR: en_b_q   <= en_b_q & ~placed;
          A_EN_B_SET: en_b_q   <= en_b_q | placed;
          A_WAKE_EN:  wk_q     <= merged;
          A_WK_CLR:   wk_q     <= wk_q & ~placed;
          A_WK_SET:   wk_q     <= wk_q | placed;
          A_CTRL:     ctrl_q   <= merged[2:0];
          A_DIR:      dir_q    <= merged;
          A_DOUT:     dout_q   <= merged;
          A_DOUT_CLR: dout_q   <= dout_q & ~placed;
          A_DOUT_SET: dout_q   <= dout_q | placed;
          A_LVL_LO:   lo_q     <= merged;
          A_LVL_HI:   hi_q     <= merged;
          A_RISE:     rise_q   <= merged;
          A_FALL:     fall_q   <= merged;
          A_DEB_EN:   deb_en_q <= merged;
          A_DEB_TIME: deb_t_q  <= merged[7:0];
          default: ;
        endcase
      end
      if (soft_rst) begin
        ctrl_q   <= CTRL_RESET;
        deb_t_q  <= '0;
        dir_q    <= '1;
        dout_q   <= '0;
        lo_q     <= '0;
        hi_q     <= '0;
        rise_q   <= '0;
        fall_q   <= '0;
        deb_en_q <= '0;
        en_a_q   <= '0;
        en_b_q   <= '0;
        wk_q     <= '0;
        st_a_q   <= '0;
        st_b_q   <= '0;
      end
    end
  end

  assign pin_drive = ~dir_q;
  assign pin_out   = dout_q & ~dir_q;
  assign irq_a     = |(st_a_q & en_a_q);
  assign irq_b     = |(st_b_q & en_b_q);
endmodule

// File: rtl/gpio32_dual_irq_chk.sv
module gpio32_dual_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_stat_a,
  input logic        wr_stat_b,
  input logic        soft_rst,
  input logic [31:0] st_a,
  input logic [31:0] st_b,
  input logic [31:0] dir,
  input logic [31:0] ev_all,
  input logic [31:0] lvl_ev,
  input logic [31:0] en_a,
  input logic [7:0]  cfg,
  input logic        wake_req,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat_a && !soft_rst) |=> ((st_a & $past(st_a)) == $past(st_a))); // R6

  AST_BANKS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_a == st_b && !wr_stat_a && !wr_stat_b) |=> (st_a == st_b)); // R4

  AST_INPUT_ONLY_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_all & ~dir) == 32'd0)); // R4

  AST_LEVEL_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst) |=> (($past(lvl_ev) & ~st_a) == 32'd0)); // R5

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(cfg[2] && (cfg[4:3] != 2'b00))); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dir == 32'hFFFF_FFFF && en_a == 32'd0 && st_a == 32'd0)); // R10

  AST_SYSSTAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h14) |-> (bus_rdata == 32'd1)); // R1
endmodule

bind gpio32_dual_irq gpio32_dual_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stat_a(wr_stat_a), .wr_stat_b(wr_stat_b),
  .soft_rst(soft_rst), .st_a(st_a_q), .st_b(st_b_q), .dir(dir_q),
  .ev_all(ev_all), .lvl_ev(lvl_ev), .en_a(en_a_q), .cfg(cfg_q),
  .wake_req(wake_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/gpio32_dual_irq_bench.sv
`timescale 1ns/1ps
module gpio32_dual_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_drive;
  logic        irq_a, irq_b, wake_req;

  int n_cmp = 0, n_bad = 0, wake_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio32_dual_irq u_gpio32_dual_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_drive(pin_drive), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
  );

  always @(negedge clk) if (wake_req === 1'b1) wake_cnt++;

  // Bench models
  function automatic logic [31:0] m_merge(input logic [31:0] cur, input logic [31:0] wd,
                                          input int sz, input int off, input bit zero_fill);
    logic [31:0] r = zero_fill ? 32'd0 : cur;
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int b = 0; b < nb; b++) r[(off+b)*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_rd(input logic [31:0] w, input int off);
    return w >> (8 * off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, 2'd2, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, mdl, r, p, e;
    void'($urandom(32'h5EED_0107));
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    rchk("R1 revision", 8'h00, 32'h25);
    rchk("R1 sysconfig", 8'h10, 32'h0);
    rchk("R1 sysstatus", 8'h14, 32'h1);
    rchk("R1 control", 8'h30, 32'h2);
    rchk("R1 direction", 8'h34, 32'hFFFF_FFFF);
    rchk("R1 status A", 8'h18, 32'h0);
    rchk("R1 enable B", 8'h2C, 32'h0);
    rchk("R1 debounce time", 8'h54, 32'h0);
    chk("R1 irq lines", {30'd0, irq_a, irq_b}, 32'd0);

    // R2 output drive
    wr(8'h34, 2'd2, 32'hFFFF_0000);
    wr(8'h3C, 2'd2, 32'h1234_ABCD);
    chk("R2 pin_out", pin_out, 32'h0000_ABCD);
    chk("R2 pin_drive", pin_drive, 32'h0000_FFFF);

    // R3 synchronizer latency
    wr(8'h34, 2'd2, 32'hFFFF_FFFF);
    idle(1);
    pin_in = 32'hA5A5_0F0F;
    rd(8'h38, 2'd2, v); chk("R3 one edge old", v, 32'h0);
    rd(8'h38, 2'd2, v); chk("R3 two edges new", v, 32'hA5A5_0F0F);

    // R4 edge detection, bit 8 is an output
    pin_in = 32'h0;
    wr(8'h34, 2'd2, 32'hFFFF_FEFF);
    wr(8'h48, 2'd2, 32'h0000_01F0);
    wr(8'h4C, 2'd2, 32'h0000_000F);
    idle(4);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    wr(8'h28, 2'd2, 32'hFFFF_FFFF);
    pin_in = 32'h0000_01FF;
    idle(4);
    rchk("R4 rising A", 8'h18, 32'h0000_00F0);
    rchk("R4 rising B", 8'h28, 32'h0000_00F0);
    pin_in = 32'h0;
    idle(4);
    rchk("R4 falling A", 8'h18, 32'h0000_00FF);
    rchk("R4 falling B", 8'h28, 32'h0000_00FF);

    // R6 clear only the written bank and bits
    wr(8'h18, 2'd2, 32'h0000_0030);
    rchk("R6 cleared A", 8'h18, 32'h0000_00CF);
    rchk("R6 bank B kept", 8'h28, 32'h0000_00FF);

    // R7 interrupt outputs
    wr(8'h1C, 2'd2, 32'h0000_0001);
    chk("R7 irq_a on", {31'd0, irq_a}, 32'd1);
    chk("R7 irq_b off", {31'd0, irq_b}, 32'd0);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    chk("R7 irq_a off", {31'd0, irq_a}, 32'd0);

    // R5 level detection re-asserts
    wr(8'h48, 2'd2, 32'h0);
    wr(8'h4C, 2'd2, 32'h0);
    wr(8'h44, 2'd2, 32'h0001_0000);
    pin_in = 32'h0001_0000;
    idle(4);
    rchk("R5 high level", 8'h18, 32'h0001_0000);
    wr(8'h18, 2'd2, 32'h0001_0000);
    rchk("R5 reasserted", 8'h18, 32'h0001_0000);
    pin_in = 32'h0;
    idle(4);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    rchk("R5 cleared", 8'h18, 32'h0);
    wr(8'h40, 2'd2, 32'h0002_0000);
    idle(1);
    rchk("R5 low level", 8'h18, 32'h0002_0000);
    wr(8'h40, 2'd2, 32'h0);
    wr(8'h44, 2'd2, 32'h0);

    // R9 wakeup gating
    wr(8'h10, 2'd2, 32'h0000_000C);
    rchk("R10 cfg stored", 8'h10, 32'h0000_000C);
    wr(8'h48, 2'd2, 32'h0010_0000);
    wr(8'h84, 2'd2, 32'h0010_0000);
    rchk("R8 wake set alias", 8'h20, 32'h0010_0000);
    idle(2); wake_cnt = 0;
    pin_in = 32'h0010_0000; idle(6);
    chk("R9 wake allowed", {31'd0, wake_cnt != 0}, 32'd1);
    wr(8'h10, 2'd2, 32'h0000_0004);
    pin_in = 32'h0; idle(4); wake_cnt = 0;
    pin_in = 32'h0010_0000; idle(6);
    chk("R9 idle bits zero", wake_cnt, 32'd0);
    wr(8'h10, 2'd2, 32'h0000_000C);
    wr(8'h80, 2'd2, 32'h0010_0000);
    pin_in = 32'h0; idle(4); wake_cnt = 0;
    pin_in = 32'h0010_0000; idle(6);
    chk("R9 line not enabled", wake_cnt, 32'd0);
    pin_in = 32'h0;

    // R10 soft reset and masking
    wr(8'h1C, 2'd2, 32'h0000_FFFF);
    wr(8'h30, 2'd2, 32'hFFFF_FFFF);
    rchk("R10 control low bits", 8'h30, 32'h7);
    wr(8'h10, 2'd2, 32'h0000_00FF);
    rchk("R10 cfg masked", 8'h10, 32'h0000_001D);
    rchk("R10 soft reset enable", 8'h1C, 32'h0);
    rchk("R10 soft reset control", 8'h30, 32'h2);
    rchk("R10 soft reset rising", 8'h48, 32'h0);

    // R11 narrow writes
    wr(8'h48, 2'd2, 32'h1122_3344);
    wr(8'h49, 2'd0, 32'h0000_00AB);
    rchk("R11 byte merge", 8'h48, 32'h1122_AB44);
    wr(8'h4A, 2'd1, 32'h0000_BEEF);
    rchk("R11 half merge", 8'h48, 32'hBEEF_AB44);
    wr(8'h65, 2'd0, 32'h0000_000F);
    rchk("R11 alias zero lanes", 8'h1C, 32'h0000_0F00);
    wr(8'h48, 2'd2, 32'h0);
    mdl = 32'h0;
    for (int i = 0; i < 16; i++) begin
      int sz = $urandom % 3;
      int off = (sz == 0) ? ($urandom % 4) : (sz == 1) ? 2 * ($urandom % 2) : 0;
      logic [31:0] d = $urandom;
      wr({6'b010100, 2'(off)}, 2'(sz), d);
      mdl = m_merge(mdl, d, sz, off, 1'b0);
      rchk("R11 random merge", 8'h50, mdl);
    end

    // R12 narrow reads
    wr(8'h4C, 2'd2, 32'hBEEF_AB44);
    rd(8'h4F, 2'd0, v); chk("R12 byte read", v, m_rd(32'hBEEF_AB44, 3));
    rd(8'h4E, 2'd1, v); chk("R12 half read", v, m_rd(32'hBEEF_AB44, 2));
    wr(8'h4C, 2'd2, 32'h0);

    // R13 read-only and undefined offsets
    wr(8'h00, 2'd2, 32'hFFFF_FFFF);
    wr(8'h14, 2'd2, 32'h0);
    wr(8'h58, 2'd2, 32'hFFFF_FFFF);
    rchk("R13 revision kept", 8'h00, 32'h25);
    rchk("R13 sysstatus kept", 8'h14, 32'h1);
    rchk("R13 undefined reads 0", 8'h58, 32'h0);

    // R8 random alias sequence on enable B and output data
    mdl = 32'h0;
    for (int i = 0; i < 20; i++) begin
      int op = $urandom % 3;
      logic [31:0] d = $urandom;
      logic [7:0] ra;
      case (op)
        0: begin wr(8'h2C, 2'd2, d); mdl = d; end
        1: begin wr(8'h70, 2'd2, d); mdl = mdl & ~d; end
        default: begin wr(8'h74, 2'd2, d); mdl = mdl | d; end
      endcase
      ra = (i % 3 == 0) ? 8'h2C : (i % 3 == 1) ? 8'h70 : 8'h74;
      rchk("R8 enable B alias", ra, mdl);
    end
    wr(8'h3C, 2'd2, 32'hF0F0_F0F0);
    wr(8'h90, 2'd2, 32'hFF00_0000);
    wr(8'h94, 2'd2, 32'h0000_000F);
    rchk("R8 data-out alias", 8'h94, 32'h00F0_F0FF);

    // R7 and R5 random level patterns
    wr(8'h2C, 2'd2, 32'h0);
    for (int i = 0; i < 8; i++) begin
      r = $urandom; p = $urandom; e = (i % 2 == 0) ? $urandom : (~(r & p));
      wr(8'h44, 2'd2, r);
      pin_in = p;
      idle(4);
      wr(8'h18, 2'd2, 32'hFFFF_FFFF);
      rchk("R5 random level status", 8'h18, r & p);
      wr(8'h1C, 2'd2, e);
      chk("R7 random irq_a", {31'd0, irq_a}, {31'd0, |(r & p & e)});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule